// File: doc/BRIEF.md
# Serial Pattern-Match Receive Shifter

This block gathers a serial bit stream into a word-wide shift register. On every shift strobe the incoming bit is placed in the lowest bit and the older bits move one place up. An external shift-count timer tells the block when a word is finished by pulsing a count-zero strobe. A mode input selects what happens on that strobe.

In receive mode the finished word is copied into a buffer register, and a receive-complete flag is raised until the buffer is read. In continuous-match mode the buffer holds a pattern that was written through the buffer write port. Every shift compares the shifter with that pattern, and a registered one-cycle match pulse plus a sticky match bit report each moment the comparison turns true. The count-zero strobe still empties the shifter in this mode, so any partly gathered bits are discarded. Because the shifter restarts from zeros, a pattern whose high bits are zero can match before all of its bits have arrived.

Top module: `serial_match_shifter`

## Requirements
- R1: After reset, `buf_q` is zero and `rx_done`, `match_pulse` and `match_sticky` are low. The shifter also starts at zero.
- R2: On each cycle with `shift_en` high, the shifter moves up one place and `sdata` enters at bit 0, so the newest bit is bit 0.
- R3: With `mode_match` low, a `count_zero` pulse loads `buf_q` on the next edge with the shifter value, including a bit shifted in during the same cycle. It also sets `rx_done`, and the shifter restarts from all zeros.
- R4: `buf_rd` clears `rx_done` on the next edge. If a transfer happens in the same cycle, `rx_done` stays set.
- R5: With `mode_match` high, `count_zero` leaves `buf_q` unchanged and clears the shifter to all zeros.
- R6: `match_pulse` is high for exactly one cycle after a shift in match mode that makes the shifter equal `buf_q` when it was unequal just before that shift. It never rises in receive mode or without a shift.
- R7: Zeros left in a cleared shifter take part in the comparison. After a clear, pattern 0x00FF matches after eight ones have been shifted in.
- R8: `match_sticky` is set together with each `match_pulse` and stays set until `match_clr` is high. A new match in the same cycle as `match_clr` keeps it set.
- R9: `buf_wr` loads `buf_wdata` into `buf_q` on the next edge. In receive mode a transfer in the same cycle takes priority over the write.
- R10: When `shift_en` and `count_zero` are high together in match mode, the comparison uses the newly shifted value, and the shifter is cleared afterwards.
- R11: In match mode `count_zero` never sets `rx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift strobe, one bit per cycle |
| sdata | input | 1 | Serial data bit |
| mode_match | input | 1 | 0 = receive, 1 = continuous match |
| count_zero | input | 1 | Shift-count timer reached zero |
| buf_wr | input | 1 | Write `buf_wdata` into the buffer |
| buf_wdata | input | W | Buffer write data (the match pattern) |
| buf_rd | input | 1 | Buffer read, clears `rx_done` |
| match_clr | input | 1 | Write-one-to-clear for `match_sticky` |
| buf_q | output | W | Buffer register contents |
| rx_done | output | 1 | Receive complete flag |
| match_pulse | output | 1 | One-cycle match indication |
| match_sticky | output | 1 | Sticky match status |

## Verification
Two functions can fall in the same cycle: the last shift of a word and the count-zero clear. The bench provokes this in both modes by raising `shift_en` and `count_zero` together. In receive mode it checks that the transferred word already contains that final bit. In match mode it checks that the final bit can complete a match before the clear, and that the clear then forces the following match to need a full eight fresh ones.

// File: rtl/serial_match_shifter.sv
module serial_match_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sdata,
  input  logic         mode_match,
  input  logic         count_zero,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_wdata,
  input  logic         buf_rd,
  input  logic         match_clr,
  output logic [W-1:0] buf_q,
  output logic         rx_done,
  output logic         match_pulse,
  output logic         match_sticky
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_next;
  logic         xfer;
  logic         hit;

  assign sh_next = shift_en ? {sh_q[W-2:0], sdata} : sh_q;
  assign xfer    = count_zero & ~mode_match;
  assign hit     = mode_match & shift_en & (sh_next == buf_q) & (sh_q != buf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q         <= '0;
      buf_q        <= '0;
      rx_done      <= 1'b0;
      match_pulse  <= 1'b0;
      match_sticky <= 1'b0;
    end else begin
      sh_q         <= count_zero ? '0 : sh_next;
      if (xfer)
        buf_q      <= sh_next;
      else if (buf_wr)
        buf_q      <= buf_wdata;
      rx_done      <= xfer | (rx_done & ~buf_rd);
      match_pulse  <= hit;
      match_sticky <= hit | (match_sticky & ~match_clr);
    end
  end

endmodule

module serial_match_shifter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_en,
  input logic         mode_match,
  input logic         count_zero,
  input logic         buf_wr,
  input logic         buf_rd,
  input logic [W-1:0] buf_q,
  input logic         rx_done,
  input logic         match_pulse,
  input logic         match_sticky
);

  a_r3_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (count_zero && !mode_match) |=> rx_done);

  a_r4_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !(count_zero && !mode_match)) |=> !rx_done);

  a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_match && !buf_wr) |=> $stable(buf_q));

  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_pulse) |-> $past(shift_en && mode_match));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && !shift_en) |=> !match_pulse);

  a_r8_sticky_follows: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> match_sticky);

  a_r11_no_done_in_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_match && !rx_done) |=> !rx_done);

endmodule

bind serial_match_shifter serial_match_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .mode_match(mode_match),
  .count_zero(count_zero), .buf_wr(buf_wr), .buf_rd(buf_rd), .buf_q(buf_q),
  .rx_done(rx_done), .match_pulse(match_pulse), .match_sticky(match_sticky)
);

// File: tb/serial_match_shifter_bench.sv
module serial_match_shifter_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, sdata = 1'b0, mode_match = 1'b0, count_zero = 1'b0;
  logic buf_wr = 1'b0, buf_rd = 1'b0, match_clr = 1'b0;
  logic [W-1:0] buf_wdata = '0;
  logic [W-1:0] buf_q;
  logic rx_done, match_pulse, match_sticky;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_match_shifter #(.W(W)) u_serial_match_shifter (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdata(sdata),
    .mode_match(mode_match), .count_zero(count_zero), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rd(buf_rd), .match_clr(match_clr),
    .buf_q(buf_q), .rx_done(rx_done), .match_pulse(match_pulse),
    .match_sticky(match_sticky)
  );

  localparam logic [W-1:0] WORDS [4] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF};

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic d, input logic cz, input logic rd,
                     input logic wr, input logic [W-1:0] wd, input logic clr);
    shift_en = s; sdata = d; count_zero = cz; buf_rd = rd;
    buf_wr = wr; buf_wdata = wd; match_clr = clr;
    @(negedge clk);
    shift_en = 0; sdata = 0; count_zero = 0; buf_rd = 0; buf_wr = 0; match_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 buf", buf_q, '0);
    chk("R1 done", {15'b0, rx_done}, 0);
    chk("R1 pulse", {15'b0, match_pulse}, 0);
    chk("R1 sticky", {15'b0, match_sticky}, 0);

    // R2 R3 table of received words, last bit shifted together with count_zero
    for (int i = 0; i < 4; i++) begin
      for (int b = W - 1; b >= 0; b--)
        cyc(1'b1, WORDS[i][b], b == 0, 1'b0, 1'b0, '0, 1'b0);
      chk("R2 R3 word", buf_q, WORDS[i]);
      chk("R3 done set", {15'b0, rx_done}, 1);
      cyc(0, 0, 0, 1, 0, '0, 0);
      chk("R4 read clears", {15'b0, rx_done}, 0);
    end

    // R3 shifter restarts from zeros after a transfer
    for (int k = 0; k < 4; k++) cyc(1, 1, k == 3, 0, 0, '0, 0);
    chk("R3 cleared restart", buf_q, 16'h000F);

    // R4 read in same cycle as transfer keeps flag
    cyc(1, 0, 1, 1, 0, '0, 0);
    chk("R4 set wins", {15'b0, rx_done}, 1);
    chk("R3 short word", buf_q, 16'h0000);
    cyc(0, 0, 0, 1, 0, '0, 0);

    // R9 buffer write, then write losing to transfer
    cyc(0, 0, 0, 0, 1, 16'h1234, 0);
    chk("R9 write", buf_q, 16'h1234);
    for (int k = 0; k < 2; k++) cyc(1, 1, 0, 0, 0, '0, 0);
    cyc(1, 0, 1, 0, 1, 16'hBEEF, 0);
    chk("R9 transfer wins", buf_q, 16'h0006);
    cyc(0, 0, 0, 1, 0, '0, 0);

    // R6 no pulse in receive mode even when equal
    cyc(0, 0, 0, 0, 1, 16'h0001, 0);
    cyc(1, 1, 0, 0, 0, '0, 0);
    chk("R6 none in receive", {15'b0, match_pulse}, 0);
    cyc(0, 0, 1, 0, 0, '0, 0);
    cyc(0, 0, 0, 1, 0, '0, 0);

    // Match mode, pattern 0x00FF
    mode_match = 1'b1;
    cyc(0, 0, 0, 0, 1, 16'h00FF, 0);
    for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, 0, '0, 0);
    cyc(0, 0, 1, 0, 0, '0, 0);
    chk("R5 buf kept", buf_q, 16'h00FF);
    chk("R11 no done", {15'b0, rx_done}, 0);
    // R7 early match on eighth one
    for (int k = 1; k <= 9; k++) begin
      cyc(1, 1, 0, 0, 0, '0, 0);
      if (k == 7) chk("R7 no match yet", {15'b0, match_pulse}, 0);
      if (k == 8) chk("R6 R7 match after eight ones", {15'b0, match_pulse}, 1);
      if (k == 9) chk("R6 one cycle", {15'b0, match_pulse}, 0);
    end
    chk("R8 sticky set", {15'b0, match_sticky}, 1);
    cyc(0, 0, 0, 0, 0, '0, 1);
    chk("R8 cleared", {15'b0, match_sticky}, 0);

    // R10 shift and count_zero in the same cycle, then R8 set-wins
    cyc(0, 0, 1, 0, 0, '0, 0);
    for (int k = 0; k < 7; k++) cyc(1, 1, 0, 0, 0, '0, 0);
    cyc(1, 1, 1, 0, 0, '0, 0);
    chk("R10 match before clear", {15'b0, match_pulse}, 1);
    cyc(0, 0, 0, 0, 0, '0, 1);
    for (int k = 1; k <= 8; k++) begin
      cyc(1, 1, 0, 0, 0, '0, k == 8);
      if (k == 7) chk("R10 R5 shifter cleared", {15'b0, match_pulse}, 0);
      if (k == 8) chk("R10 fresh match", {15'b0, match_pulse}, 1);
    end
    chk("R8 set wins over clear", {15'b0, match_sticky}, 1);
    chk("R11 still no done", {15'b0, rx_done}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule